// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous fast page mode DRAM whose words are 4 bits wide. The host issues single-word reads and writes on a valid/ready port with a 22-bit word address. The controller splits that address into a row half and a column half and presents both, one after the other, on one shared address bus. The row is captured by the DRAM when the row strobe falls, and the column is captured when the column strobe falls.

After a column cycle the row strobe stays low, so the page stays open. A following request to the same row costs only a new column cycle. The page is closed, column strobe first and row strobe second, in three cases: a request goes to a different row, a refresh is requested, or the row strobe has been low long enough that one more column cycle could break the maximum low-time limit. Every analog timing figure is a parameter counted in clock cycles, rounded up from nanoseconds at the chosen clock period. A separate refresh block asks for the bus with `ref_req`. It receives `ref_gnt` only while the DRAM is idle and precharged.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row half `req_addr[21:11]` is on `dram_addr` when `ras_n` falls. The column half `req_addr[10:0]` is on `dram_addr` when `cas_n` falls. Each value is already on the bus at least one cycle before its strobe falls.
- R2: During and after reset, `ras_n`, `cas_n`, `we_n` and `oe_n` are 1, and `dq_oe`, `rd_valid` and `ref_gnt` are 0. When `ref_req` is low, `req_ready` is 1 in the first cycle after reset.
- R3: The first fall of `cas_n` after a fall of `ras_n` comes exactly T_RCD cycles after the `ras_n` fall.
- R4: In every column cycle, `cas_n` stays low for exactly T_CAS cycles.
- R5: Between two column cycles in the same open row, `cas_n` stays high for at least T_CP cycles.
- R6: Once `ras_n` falls, it stays low for at least T_RAS cycles.
- R7: `ras_n` never stays low for more than T_RASMAX cycles. An open page with no traffic is closed on its own before that limit.
- R8: Once `ras_n` rises, it stays high for at least T_RP cycles before it falls again.
- R9: A request to the row that is already open is served without a new fall of `ras_n`. A request to another row closes the page and then opens the new row. `ras_n` only changes while `cas_n` is high.
- R10: For a write (`req_write`=1), `we_n` is 0 and `dq_oe` is 1 with `dq_out` = write data, starting at least one cycle before `cas_n` falls and lasting until `cas_n` rises. `oe_n` stays 1 during a write.
- R11: For a read (`req_write`=0), `we_n` stays 1 and `oe_n` goes to 0 together with `cas_n`. `dq_in` is sampled on the edge at which `cas_n` rises. The sampled value appears on `rd_data` with `rd_valid` high for exactly one cycle.
- R12: While `ref_req` is 1, no host request is accepted and an open page is closed. `ref_gnt` is 1 only while both strobes are high, the precharge wait is over, and no cycle is in progress.
- R13: `req_ready` is 0 while a row open, a column cycle, a page close or a precharge is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken on this edge when valid is also high |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 22 | Word address: row in the upper 11 bits, column in the lower 11 bits |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle pulse that marks read data |
| rd_data | output | 4 | Read data |
| ref_req | input | 1 | Refresh block asks for the DRAM |
| ref_gnt | output | 1 | DRAM idle and precharged, handed to the refresh block |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Shared row/column address bus |
| dq_out | output | 4 | Data driven toward the DRAM |
| dq_oe | output | 1 | Enable for the data pad drivers |
| dq_in | input | 4 | Data returned by the DRAM |

## Verification
The bound checker keeps its own run-length counters on the strobes. On every cycle it checks the exact RAS-to-CAS delay, the exact CAS low width, the minimum CAS and RAS high times, the minimum and maximum RAS low times, CAS being high whenever RAS changes, the early-write setup, the one-cycle read pulse and the grant only while idle. Some behaviour only shows up in the bench's DRAM model and reference memory: that the correct row and column reach the bus, that data round-trips, and that a hit reuses the open row while a miss opens a new one. The bench's scenarios cover this, including page expiry after an idle gap and refresh requests that arrive while a page is open.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_RCD,
    ST_COL,
    ST_CAS,
    ST_CPW,
    ST_OPEN,
    ST_CLOSE,
    ST_PRE
  } fpm_state_e;

  // cycles still needed after the fixed cycles the sequence spends anyway
  function automatic int pad_cycles(int need, int fixed_part);
    return (need > fixed_part) ? need - fixed_part : 0;
  endfunction

  // edge of accepting a hit to earliest RAS rise: COL + CAS + pad + OPEN + CLOSE
  function automatic int hit_span(int t_cas, int cp_pad);
    return t_cas + cp_pad + 3;
  endfunction

endpackage

// File: rtl/fpm_phase_timer.sv
module fpm_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/fpm_ras_age.sv
module fpm_ras_age #(
  parameter int LIMIT = 10000,
  parameter int MIN_LOW = 5,
  parameter int SPAN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic min_ok,
  output logic near_max
);
  localparam int AW = $clog2(LIMIT + 2);
  logic [AW-1:0] age_q;

  // age_q = cycles RAS has been low before the current edge, minus one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (!ras_low)       age_q <= '0;
    else if (age_q != '1)    age_q <= age_q + 1'b1;
  end

  assign min_ok   = (int'(age_q) + 1 >= MIN_LOW);
  assign near_max = (int'(age_q) + 1 + SPAN > LIMIT);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W    = 11,
  parameter int COL_W    = 11,
  parameter int DATA_W   = 4,
  parameter int T_RCD    = 2,
  parameter int T_CAS    = 2,
  parameter int T_CP     = 1,
  parameter int T_RAS    = 5,
  parameter int T_RP     = 3,
  parameter int T_RASMAX = 10000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic                   oe_n,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DATA_W-1:0]      dq_out,
  output logic                   dq_oe,
  input  logic [DATA_W-1:0]      dq_in
);
  localparam int CP_PAD  = pad_cycles(T_CP, 2);
  localparam int RP_WAIT = (pad_cycles(T_RP, 2) > 0) ? pad_cycles(T_RP, 2) : 1;
  localparam int SPAN    = hit_span(T_CAS, CP_PAD);
  localparam int TW      = $clog2(T_RCD + T_CAS + T_CP + T_RP + 2);

  fpm_state_e state_q, nxt;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wd_q;
  logic              wr_q;
  logic              tm_load, tm_done;
  logic [TW-1:0]     tm_val;
  logic              min_ok, near_max;

  // named events for checking
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             row_hit, host_take, page_close;

  assign req_row   = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col   = req_addr[COL_W-1:0];
  assign row_hit   = (req_row == row_q);
  assign req_ready = !ref_req && ((state_q == ST_IDLE) ||
                     (state_q == ST_OPEN && !near_max && row_hit));
  assign host_take = req_valid && req_ready;
  assign page_close = (state_q == ST_OPEN) &&
                      (ref_req || near_max || (req_valid && !row_hit));
  assign ref_gnt   = (state_q == ST_IDLE) && ref_req;

  fpm_phase_timer #(.W(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .done(tm_done)
  );

  fpm_ras_age #(.LIMIT(T_RASMAX), .MIN_LOW(T_RAS), .SPAN(SPAN)) age_i (
    .clk(clk), .rst_n(rst_n), .ras_low(!ras_n), .min_ok(min_ok), .near_max(near_max)
  );

  always_comb begin
    nxt     = state_q;
    tm_load = 1'b0;
    tm_val  = '0;
    unique case (state_q)
      ST_IDLE:  if (host_take) nxt = ST_ROW;
      ST_ROW:   begin nxt = ST_RCD; tm_load = 1'b1; tm_val = TW'(T_RCD - 2); end
      ST_RCD:   if (tm_done) nxt = ST_COL;
      ST_COL:   begin nxt = ST_CAS; tm_load = 1'b1; tm_val = TW'(T_CAS - 1); end
      ST_CAS:   if (tm_done) begin
                  if (CP_PAD != 0) begin
                    nxt = ST_CPW; tm_load = 1'b1; tm_val = TW'(CP_PAD - 1);
                  end else nxt = ST_OPEN;
                end
      ST_CPW:   if (tm_done) nxt = ST_OPEN;
      ST_OPEN:  if (page_close) nxt = ST_CLOSE;
                else if (host_take) nxt = ST_COL;
      ST_CLOSE: if (min_ok) begin
                  nxt = ST_PRE; tm_load = 1'b1; tm_val = TW'(RP_WAIT - 1);
                end
      ST_PRE:   if (tm_done) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      wd_q      <= '0;
      wr_q      <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dram_addr <= '0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      state_q  <= nxt;
      rd_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (host_take) begin
          row_q     <= req_row;
          col_q     <= req_col;
          wd_q      <= req_wdata;
          wr_q      <= req_write;
          dram_addr <= req_row;
        end
        ST_ROW: ras_n <= 1'b0;
        ST_RCD: if (tm_done) begin
          dram_addr <= ROW_W'(col_q);
          we_n      <= !wr_q;
          dq_oe     <= wr_q;
          dq_out    <= wd_q;
        end
        ST_COL: begin
          cas_n <= 1'b0;
          oe_n  <= wr_q;
        end
        ST_CAS: if (tm_done) begin
          cas_n <= 1'b1;
          oe_n  <= 1'b1;
          we_n  <= 1'b1;
          dq_oe <= 1'b0;
          if (!wr_q) begin
            rd_valid <= 1'b1;
            rd_data  <= dq_in;
          end
        end
        ST_OPEN: if (nxt == ST_COL) begin
          col_q     <= req_col;
          wd_q      <= req_wdata;
          wr_q      <= req_write;
          dram_addr <= ROW_W'(req_col);
          we_n      <= !req_write;
          dq_oe     <= req_write;
          dq_out    <= req_wdata;
        end
        ST_CLOSE: if (min_ok) ras_n <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RCD    = 2,
  parameter int T_CAS    = 2,
  parameter int T_CP     = 1,
  parameter int T_RAS    = 5,
  parameter int T_RP     = 3,
  parameter int T_RASMAX = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic rd_valid,
  input logic ref_gnt,
  input logic req_ready
);
  int  rlo, rhi, clo, chi;
  logic col_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rlo <= 0; rhi <= T_RP; clo <= 0; chi <= T_CP; col_seen <= 1'b0;
    end else begin
      rlo <= ras_n ? 0 : rlo + 1;
      rhi <= !ras_n ? 0 : ((rhi >= T_RP) ? rhi : rhi + 1);
      clo <= cas_n ? 0 : clo + 1;
      chi <= !cas_n ? 0 : ((chi >= T_CP) ? chi : chi + 1);
      col_seen <= ras_n ? 1'b0 : (col_seen | !cas_n);
    end
  end

  a_r3_ras_to_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !col_seen |-> rlo == T_RCD);
  a_r4_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> clo == T_CAS);
  a_r5_cas_pre: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && col_seen |-> chi >= T_CP);
  a_r6_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> rlo >= T_RAS);
  a_r7_ras_max: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> rlo < T_RASMAX);
  a_r8_ras_pre: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> rhi >= T_RP);
  a_r9_strobe_order: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) || $fell(ras_n)) |-> cas_n);
  a_r10_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !we_n |-> $past(!we_n) && dq_oe && oe_n);
  a_r10_we_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n && !$fell(cas_n) |-> $stable(we_n) && $stable(dq_oe));
  a_r11_read_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && we_n |-> !oe_n && !dq_oe);
  a_r11_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r12_gnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> ras_n && cas_n && !dq_oe && !req_ready);
  a_r13_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !req_ready);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
  .T_RAS(T_RAS), .T_RP(T_RP), .T_RASMAX(T_RASMAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .rd_valid(rd_valid), .ref_gnt(ref_gnt),
  .req_ready(req_ready)
);

// File: tb/fpm_dram_ctrl_tb.sv
module fpm_dram_ctrl_tb_top;
  localparam int P_RCD = 3, P_CAS = 2, P_CP = 3, P_RAS = 6, P_RP = 4, P_MAX = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, rd_valid, ref_gnt, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0]  rd_data, dq_out;
  logic [3:0]  dq_in = '0;
  logic [10:0] dram_addr;

  int checks = 0, bad = 0, acts = 0;
  bit done = 0, mon_on = 0;

  always #5 clk = ~clk;

  fpm_dram_ctrl #(.T_RCD(P_RCD), .T_CAS(P_CAS), .T_CP(P_CP), .T_RAS(P_RAS),
                  .T_RP(P_RP), .T_RASMAX(P_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .dram_addr(dram_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] init_val(input logic [21:0] a);
    return a[3:0] ^ a[14:11] ^ a[21:18] ^ 4'hA;
  endfunction

  // DRAM model
  logic [3:0]  mmem [int];
  logic [10:0] m_row = '0, m_col = '0;
  always @(negedge ras_n) begin
    m_row = dram_addr;
    acts++;
  end
  always @(negedge cas_n) begin
    m_col = dram_addr;
    if (!we_n) mmem[int'({m_row, m_col})] = dq_out;
    else dq_in = mmem.exists(int'({m_row, m_col})) ? mmem[int'({m_row, m_col})]
                                                   : init_val({m_row, m_col});
  end

  // reference memory
  logic [3:0] emem [int];
  function automatic logic [3:0] exp_rd(input logic [21:0] a);
    return emem.exists(int'(a)) ? emem[int'(a)] : init_val(a);
  endfunction

  // strobe timing monitor, sampled at the falling clock edge
  int rrun = 100, crun = 100, n_rcd = 0, n_hit = 0, n_rvp = 0;
  bit ras_p = 1, cas_p = 1, we_p = 1, rv_p = 0, seen = 0;
  always @(negedge clk) if (mon_on) begin
    if (ras_n != ras_p) begin
      if (!ras_n) chk(rrun >= P_RP, "R8 ras high time", rrun, P_RP);
      else begin
        chk(rrun >= P_RAS, "R6 ras low time", rrun, P_RAS);
        chk(rrun <= P_MAX, "R7 ras low limit", rrun, P_MAX);
        seen = 0;
      end
      rrun = 1;
    end else rrun++;
    if (!ras_n && rrun > P_MAX) chk(0, "R7 ras still low", rrun, P_MAX);
    if (cas_n != cas_p) begin
      if (!cas_n) begin
        chk(ras_n == 0, "R9 cas under open row", ras_n, 0);
        if (!seen) begin
          chk(rrun == P_RCD + 1, "R3 ras to cas", rrun - 1, P_RCD);
          n_rcd++;
        end else begin
          chk(crun >= P_CP, "R5 cas precharge", crun, P_CP);
          n_hit++;
        end
        if (!we_n) chk(!we_p && dq_oe && oe_n, "R10 early write setup",
                       {we_p, dq_oe, oe_n}, 3'b010 | 3'b001);
        else chk(!oe_n && !dq_oe, "R11 read enable", {oe_n, dq_oe}, 0);
        seen = 1;
      end else chk(crun == P_CAS, "R4 cas width", crun, P_CAS);
      crun = 1;
    end else crun++;
    if (ras_n != ras_p) chk(cas_n == 1, "R9 cas high at ras edge", cas_n, 1);
    if (rd_valid && rv_p) begin chk(0, "R11 rvalid pulse", 2, 1); end
    if (rd_valid) n_rvp++;
    if (ref_gnt) chk(ras_n && cas_n, "R12 grant while idle", {ras_n, cas_n}, 3);
    ras_p = ras_n; cas_p = cas_n; we_p = we_n; rv_p = rd_valid;
  end

  task automatic do_req(input bit wr, input logic [21:0] a, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    chk(req_ready == 0, "R13 busy after accept", req_ready, 0);
    req_valid = 0;
    if (wr) emem[int'(a)] = d;
  endtask

  task automatic do_read(input logic [21:0] a, input string req);
    logic [3:0] e;
    e = exp_rd(a);
    do_req(0, a, 4'h0);
    while (!rd_valid) @(negedge clk);
    chk(rd_data == e, req, rd_data, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int a0;
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    // R2: reset values
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R2 strobes in reset", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe && !rd_valid && !ref_gnt, "R2 outputs in reset", {dq_oe, rd_valid, ref_gnt}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R2 ready after reset", req_ready, 1);
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R2 strobes after reset", {ras_n, cas_n, we_n, oe_n}, 15);
    mon_on = 1;

    // R1/R9/R10/R11: write then read in the same row
    a0 = acts;
    do_req(1, {11'd5, 11'd9}, 4'h3);
    do_read({11'd5, 11'd9}, "R11 read back write");
    chk(m_row == 11'd5 && m_col == 11'd9, "R1 row/col on bus", {m_row, m_col}, {11'd5, 11'd9});
    chk(acts - a0 == 1, "R9 hit keeps row", acts - a0, 1);
    do_req(1, {11'd5, 11'd10}, 4'hC);
    do_read({11'd5, 11'd10}, "R10 write data hit");
    chk(acts - a0 == 1, "R9 second hit keeps row", acts - a0, 1);

    // R9 miss
    do_read({11'd1234 & 11'h7FF, 11'd10}, "R11 read untouched cell");
    chk(acts - a0 == 2, "R9 miss opens row", acts - a0, 2);
    chk(m_row == (11'd1234 & 11'h7FF), "R1 row after miss", m_row, 1234);

    // R7 idle page expiry
    repeat (P_MAX + 10) @(negedge clk);
    chk(ras_n == 1, "R7 idle page closed", ras_n, 1);

    // R12 refresh while page open
    do_read({11'd7, 11'd1}, "R11 read before refresh");
    ref_req = 1; req_valid = 1; req_write = 0; req_addr = {11'd7, 11'd2};
    a0 = acts;
    for (int i = 0; i < 30 && !ref_gnt; i++) begin
      @(negedge clk); #1;
      chk(req_ready == 0, "R12 no accept under refresh", req_ready, 0);
    end
    chk(ref_gnt == 1, "R12 grant reached", ref_gnt, 1);
    chk(ras_n && cas_n, "R12 page closed for refresh", {ras_n, cas_n}, 3);
    repeat (5) @(negedge clk);
    chk(acts == a0 && rd_valid == 0, "R12 request held off", acts - a0, 0);
    req_valid = 0; ref_req = 0;
    @(negedge clk);
    chk(ref_gnt == 0, "R12 grant drops", ref_gnt, 0);

    // random traffic
    for (int n = 0; n < 300; n++) begin
      logic [10:0] r, c;
      logic [3:0]  d;
      r = (n % 7 == 0) ? 11'($urandom) : 11'(($urandom % 3) * 331);
      c = 11'($urandom % 8);
      d = 4'($urandom);
      if ($urandom % 2) do_req(1, {r, c}, d);
      else do_read({r, c}, "R11 random read");
      if ($urandom % 5 == 0) repeat ($urandom % 46) @(negedge clk);
      if ($urandom % 25 == 0) begin
        ref_req = 1;
        while (!ref_gnt) @(negedge clk);
        repeat (3) @(negedge clk);
        ref_req = 0;
      end
    end
    repeat (60) @(negedge clk);
    chk(n_rcd > 0, "R3 row opens seen", n_rcd, 1);
    chk(n_hit > 0, "R5 page hits seen", n_hit, 1);
    chk(n_rvp > 0, "R11 read pulses seen", n_rvp, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule